// File: doc/BRIEF.md
# GPIO Event Notification Router

This block sits behind a bank of GPIO event detectors. It takes the vector of pins that are currently in the event-pending state and turns it into two system notification levels: an interrupt request toward the host interrupt logic and a system management interrupt toward the wake-up logic. A two-bit routing input selects which of the two targets, if any, a pending event reaches.

The two targets follow different power rules. The interrupt path is live only while the GPIO block is active and main power is good. The management interrupt path ignores block activation. While main power is off, it drops only those pins whose attached device runs from main power. Pins whose device runs from standby power keep raising it. Both outputs are registered active-high levels.

Top module: `gpio_evt_router`

## Requirements
- R1: `irq_req_o` is high in the cycle after one in which `route_i[0]`, `blk_active_i` and `main_pwr_ok_i` are all 1 and at least one bit of `pend_i` is 1.
- R2: Routing bit 0 enables the interrupt target and routing bit 1 enables the management target. With a bit at 0, its output is low in the next cycle whatever else is pending.
- R3: `irq_req_o` is low in the cycle after any cycle in which `blk_active_i` is 0 or `main_pwr_ok_i` is 0.
- R4: `smi_req_o` does not depend on `blk_active_i`. With `route_i[1]` = 1, `main_pwr_ok_i` = 1 and any pin pending, it is high in the next cycle.
- R5: While `main_pwr_ok_i` is 0, a pending pin whose `pin_on_main_i` bit is 1 cannot raise `smi_req_o`.
- R6: While `main_pwr_ok_i` is 0, a pending pin whose `pin_on_main_i` bit is 0 raises `smi_req_o` in the next cycle when `route_i[1]` = 1.
- R7: Each output falls in the cycle after the one in which its qualifying condition goes away.
- R8: During reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NPINS | Per-pin event-pending flags |
| pin_on_main_i | input | NPINS | 1 = the pin's device runs from main power, 0 = from standby power |
| main_pwr_ok_i | input | 1 | Main power good |
| blk_active_i | input | 1 | GPIO block activated |
| route_i | input | 2 | Bit 0 routes to interrupt, bit 1 routes to management interrupt |
| irq_req_o | output | 1 | Registered interrupt request level |
| smi_req_o | output | 1 | Registered management interrupt request level |

## Verification
On every cycle, the assertions check the gating rules as implications from the previous cycle's inputs to the present outputs. They cover routing masks, power and activation suppression of the interrupt, standby pins forcing the management interrupt, and main-powered pins being unable to raise it. Only the bench's exhaustive sweep over a four-pin bank shows that every mix of pending and power-flag patterns gives exactly the right level on both outputs. The same sweep shows that the outputs fall one cycle after the condition leaves.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int ROUTE_W   = 2;
    localparam int ROUTE_IRQ = 0;
    localparam int ROUTE_SMI = 1;

    typedef struct packed {
        logic irq;
        logic smi;
    } notify_t;

endpackage

// File: rtl/gpio_evt_smi_mask.sv
module gpio_evt_smi_mask #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] pend_i,
    input  logic [NPINS-1:0] pin_on_main_i,
    input  logic             main_pwr_ok_i,
    output logic [NPINS-1:0] live_o
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        // a pin on main power counts only while main power is good
        assign live_o[p] = pend_i[p] & (~pin_on_main_i[p] | main_pwr_ok_i);
    end
endmodule

// File: rtl/gpio_evt_any.sv
module gpio_evt_any #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             any_o
);
    assign any_o = |vec_i;
endmodule

// File: rtl/gpio_evt_router.sv
module gpio_evt_router
    import gpio_evt_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   pend_i,
    input  logic [NPINS-1:0]   pin_on_main_i,
    input  logic               main_pwr_ok_i,
    input  logic               blk_active_i,
    input  logic [ROUTE_W-1:0] route_i,
    output logic               irq_req_o,
    output logic               smi_req_o
);
    logic [NPINS-1:0] smi_live;
    logic             any_pend;
    logic             any_smi;
    notify_t          out_d, out_q;

    gpio_evt_smi_mask #(.NPINS(NPINS)) i_mask (
        .pend_i        (pend_i),
        .pin_on_main_i (pin_on_main_i),
        .main_pwr_ok_i (main_pwr_ok_i),
        .live_o        (smi_live)
    );

    gpio_evt_any #(.WIDTH(NPINS)) i_any_irq (
        .vec_i (pend_i),
        .any_o (any_pend)
    );

    gpio_evt_any #(.WIDTH(NPINS)) i_any_smi (
        .vec_i (smi_live),
        .any_o (any_smi)
    );

    always_comb begin
        out_d     = out_q;
        out_d.irq = route_i[ROUTE_IRQ] & blk_active_i & main_pwr_ok_i & any_pend;
        out_d.smi = route_i[ROUTE_SMI] & any_smi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_req_o = out_q.irq;
    assign smi_req_o = out_q.smi;
endmodule

// File: rtl/gpio_evt_router_chk.sv
module gpio_evt_router_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pend_i,
    input logic [NPINS-1:0] pin_on_main_i,
    input logic             main_pwr_ok_i,
    input logic             blk_active_i,
    input logic [1:0]       route_i,
    input logic             irq_req_o,
    input logic             smi_req_o
);
    assert_irq_raise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (route_i[0] && blk_active_i && main_pwr_ok_i && (|pend_i)) |=> irq_req_o);

    assert_irq_unrouted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !route_i[0] |=> !irq_req_o);

    assert_smi_unrouted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !route_i[1] |=> !smi_req_o);

    assert_irq_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_active_i || !main_pwr_ok_i) |=> !irq_req_o);

    assert_smi_no_activation_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (route_i[1] && main_pwr_ok_i && (|pend_i)) |=> smi_req_o);

    assert_smi_main_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_pwr_ok_i && ((pend_i & ~pin_on_main_i) == '0)) |=> !smi_req_o);

    assert_smi_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (route_i[1] && ((pend_i & ~pin_on_main_i) != '0)) |=> smi_req_o);

    assert_idle_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> (!irq_req_o && !smi_req_o));

    always_comb begin
        if (!rst_n) begin
            assert_reset_low_R8: assert (!irq_req_o && !smi_req_o);
        end
    end
endmodule

bind gpio_evt_router gpio_evt_router_chk #(.NPINS(NPINS)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pend_i        (pend_i),
    .pin_on_main_i (pin_on_main_i),
    .main_pwr_ok_i (main_pwr_ok_i),
    .blk_active_i  (blk_active_i),
    .route_i       (route_i),
    .irq_req_o     (irq_req_o),
    .smi_req_o     (smi_req_o)
);

// File: tb/test_gpio_evt_router.sv
module test_gpio_evt_router;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pend = '0;
    logic [N-1:0] onmain = '0;
    logic         pwr = 1'b0;
    logic         act = 1'b0;
    logic [1:0]   route = 2'b00;
    logic         irq, smi;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gpio_evt_router #(.NPINS(N)) i_gpio_evt_router (
        .clk           (clk),
        .rst_n         (rst_n),
        .pend_i        (pend),
        .pin_on_main_i (onmain),
        .main_pwr_ok_i (pwr),
        .blk_active_i  (act),
        .route_i       (route),
        .irq_req_o     (irq),
        .smi_req_o     (smi)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%b exp=%b pend=%b main=%b pwr=%b act=%b route=%b",
                     tag, got, exp, pend, onmain, pwr, act, route);
        end
    endtask

    // apply inputs at negedge, sample at following negedge (one register)
    task automatic apply(input logic [N-1:0] p, input logic [N-1:0] m,
                         input logic pw, input logic a, input logic [1:0] r);
        logic exp_irq, exp_smi;
        pend = p; onmain = m; pwr = pw; act = a; route = r;
        exp_irq = r[0] & a & pw & (p != '0);
        exp_smi = r[1] & ((p & (~m | {N{pw}})) != '0);
        @(negedge clk);
        check("R1 R2 R3 R7 irq", irq, exp_irq);
        check("R2 R4 R5 R6 R7 smi", smi, exp_smi);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        pend = '1; pwr = 1'b1; act = 1'b1; route = 2'b11;
        @(negedge clk);
        // R8: outputs held low under reset despite qualifying inputs
        check("R8 irq reset", irq, 1'b0);
        check("R8 smi reset", smi, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: activation off, main power on, routed: smi high, irq low
        apply(4'b0010, 4'b0010, 1'b1, 1'b0, 2'b11);
        // R5: only a main-powered pin pending with power off: smi low
        apply(4'b0100, 4'b0100, 1'b0, 1'b1, 2'b11);
        // R6: standby pin pending with power off: smi high
        apply(4'b0001, 4'b0000, 1'b0, 1'b0, 2'b10);
        // R7: condition removed, both fall next cycle
        apply(4'b0000, 4'b0000, 1'b1, 1'b1, 2'b11);

        // exhaustive sweep of all input combinations
        for (int r = 0; r < 4; r++)
            for (int a = 0; a < 2; a++)
                for (int pw = 0; pw < 2; pw++)
                    for (int m = 0; m < (1 << N); m++)
                        for (int p = 0; p < (1 << N); p++)
                            apply(N'(p), N'(m), pw[0], a[0], r[1:0]);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule